// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block sits beside the execute stage of a five-stage in-order pipeline and decides, for each of the two ALU operands, where that operand should come from. The choices are the value read from the register file during decode, the result held in the execute/memory pipeline register, or the result held in the memory/writeback pipeline register. It compares the two source register numbers of the instruction now entering execute against the destinations of the two older instructions still in flight. It also looks at whether each of those older instructions writes a register.

The logic is purely combinational and has no clock. The two selects are meant to drive the operand multiplexers directly, in the same cycle as the comparison. When both older instructions write the register an operand needs, the younger of the two (the one in execute/memory) is chosen, because it holds the newest value. Register zero is hardwired, so a destination of zero never produces a forward.

Top module: `fwd_select`

## Requirements
- R1: A select is 2'b00 (register file) whenever neither older instruction is a live producer of that operand's source register.
- R2: A select is 2'b10 (execute/memory result) when the execute/memory instruction writes a register, its destination is not zero, and its destination equals that operand's source register.
- R3: A select is 2'b01 (memory/writeback result) when the memory/writeback instruction writes a register, its destination is not zero and equals that operand's source register, and the R2 condition is false for that operand.
- R4: When both older instructions are live producers of the same source register, the select is 2'b10. In a chain of three dependent adds to one register, with both sources equal to that register, both selects are 2'b10.
- R5: An older instruction whose register-write flag is clear never causes a forward from its stage, even when its destination matches.
- R6: A destination register number of zero never causes a forward, whatever the write flag says.
- R7: The two selects are decided independently, so operand A and operand B may take different sources in the same cycle.
- R8: A select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | REG_W (5) | First source register number of the instruction in decode/execute |
| src_b | input | REG_W (5) | Second source register number of the instruction in decode/execute |
| mem_dst | input | REG_W (5) | Destination register number of the instruction in execute/memory |
| mem_wr | input | 1 | Register-write flag of the instruction in execute/memory |
| wb_dst | input | REG_W (5) | Destination register number of the instruction in memory/writeback |
| wb_wr | input | 1 | Register-write flag of the instruction in memory/writeback |
| sel_a | output | 2 | Source select for operand A: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Source select for operand B, same encoding as sel_a |

## Verification
Both selects are due in the same cycle as the register numbers and write flags that produce them: no register lies on the path, so the latency is zero cycles. The bench applies a new set of inputs on each rising edge and queues the expected selects. It pops and compares them on the falling edge half a period later, when the inputs have settled and none is changing. Directed cases cover each stage alone, both stages together, a cleared write flag, destination zero and split sources. An exhaustive sweep over a four-register subset then covers the remaining combinations against a model written from the requirements.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);
  localparam int         NUM_OPS = 2;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;

  logic             mem_live;
  logic             wb_live;
  logic [REG_W-1:0] src [NUM_OPS];
  logic [1:0]       sel [NUM_OPS];

  assign mem_live = mem_wr && (mem_dst != '0);
  assign wb_live  = wb_wr  && (wb_dst  != '0);

  assign src[0] = src_a;
  assign src[1] = src_b;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic hit_mem;
    logic hit_wb;
    assign hit_mem = mem_live && (mem_dst == src[i]);
    assign hit_wb  = wb_live  && (wb_dst  == src[i]);
    assign sel[i]  = hit_mem ? SEL_MEM : (hit_wb ? SEL_WB : SEL_RF);
  end

  assign sel_a = sel[0];
  assign sel_b = sel[1];
endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] src_a,
  input logic [REG_W-1:0] src_b,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wr,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wr,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b
);
  always_comb begin
    assert_never_eleven_R8: assert (sel_a != 2'b11 && sel_b != 2'b11);
    assert_mem_wins_a_R2: assert (!(mem_wr && |mem_dst && mem_dst == src_a) || sel_a == 2'b10);
    assert_mem_wins_b_R2: assert (!(mem_wr && |mem_dst && mem_dst == src_b) || sel_b == 2'b10);
    assert_wb_fwd_a_R3: assert (!(wb_wr && |wb_dst && wb_dst == src_a && sel_a != 2'b10) || sel_a == 2'b01);
    assert_wb_fwd_b_R3: assert (!(wb_wr && |wb_dst && wb_dst == src_b && sel_b != 2'b10) || sel_b == 2'b01);
    assert_mem_needs_writer_a_R5: assert (sel_a != 2'b10 || (mem_wr && mem_dst == src_a));
    assert_mem_needs_writer_b_R5: assert (sel_b != 2'b10 || (mem_wr && mem_dst == src_b));
    assert_wb_needs_writer_a_R5: assert (sel_a != 2'b01 || (wb_wr && wb_dst == src_a));
    assert_wb_needs_writer_b_R5: assert (sel_b != 2'b01 || (wb_wr && wb_dst == src_b));
    assert_zero_silent_a_R6: assert (sel_a == 2'b00 || src_a != '0);
    assert_zero_silent_b_R6: assert (sel_b == 2'b00 || src_b != '0);
    assert_rf_default_a_R1: assert (sel_a != 2'b00 || !((mem_wr && |mem_dst && mem_dst == src_a) || (wb_wr && |wb_dst && wb_dst == src_a)));
    assert_rf_default_b_R1: assert (sel_b != 2'b00 || !((mem_wr && |mem_dst && mem_dst == src_b) || (wb_wr && |wb_dst && wb_dst == src_b)));
  end
endmodule

bind fwd_select fwd_select_chk #(.REG_W(REG_W)) u_fwd_select_chk (
  .src_a(src_a), .src_b(src_b), .mem_dst(mem_dst), .mem_wr(mem_wr),
  .wb_dst(wb_dst), .wb_wr(wb_wr), .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/test_fwd_select.sv
module test_fwd_select;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;

  typedef struct {
    logic [1:0] exp_a;
    logic [1:0] exp_b;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] src_a = '0, src_b = '0, mem_dst = '0, wb_dst = '0;
  logic mem_wr = 1'b0, wb_wr = 1'b0;
  logic [1:0] sel_a, sel_b;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_select #(.REG_W(REG_W)) i_fwd_select (
    .src_a(src_a), .src_b(src_b), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .sel_a(sel_a), .sel_b(sel_b)
  );

  function automatic logic [1:0] model(input logic [REG_W-1:0] s,
                                       input logic [REG_W-1:0] md, input logic mw,
                                       input logic [REG_W-1:0] wd, input logic ww);
    logic [1:0] r;
    r = 2'b00;
    if (ww && wd == s && wd != 0) r = 2'b01;
    if (mw && md == s && md != 0) r = 2'b10;
    return r;
  endfunction

  task automatic apply(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                       input logic [REG_W-1:0] md, input logic mw,
                       input logic [REG_W-1:0] wd, input logic ww,
                       input logic [1:0] ea, input logic [1:0] eb, input string tag);
    item_t it;
    @(posedge clk);
    src_a = a; src_b = b; mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
    it.exp_a = ea; it.exp_b = eb; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (sel_a !== it.exp_a || sel_b !== it.exp_b) begin
        errors++;
        $display("FAIL %s: sel_a=%b sel_b=%b expected %b %b", it.tag, sel_a, sel_b, it.exp_a, it.exp_b);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state, all zero: R1 and R6
    apply(0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "R1 idle");
    apply(0, 0, 0, 1, 0, 1, 2'b00, 2'b00, "R6 dest zero with write");
    apply(3, 4, 3, 1, 9, 1, 2'b10, 2'b00, "R2 mem on A");
    apply(3, 4, 4, 1, 9, 1, 2'b00, 2'b10, "R2 mem on B");
    apply(7, 8, 1, 1, 7, 1, 2'b01, 2'b00, "R3 wb on A");
    apply(7, 8, 1, 1, 8, 1, 2'b00, 2'b01, "R3 wb on B");
    apply(1, 1, 1, 1, 1, 1, 2'b10, 2'b10, "R4 chain of three adds");
    apply(5, 6, 5, 1, 5, 1, 2'b10, 2'b00, "R4 double hazard A");
    apply(5, 5, 5, 0, 5, 1, 2'b01, 2'b01, "R5 mem not writing falls to wb");
    apply(5, 5, 5, 0, 5, 0, 2'b00, 2'b00, "R5 neither writing");
    apply(9, 9, 2, 1, 9, 0, 2'b00, 2'b00, "R5 wb not writing");
    apply(0, 0, 0, 1, 0, 1, 2'b00, 2'b00, "R6 zero source and dests");
    apply(0, 12, 0, 1, 12, 1, 2'b00, 2'b01, "R6 zero mem dest, wb on B");
    apply(10, 11, 10, 1, 11, 1, 2'b10, 2'b01, "R7 split sources");
    apply(11, 10, 10, 1, 11, 1, 2'b01, 2'b10, "R7 split swapped");
    apply(31, 31, 31, 1, 30, 1, 2'b10, 2'b10, "R2 top register");
    // exhaustive sweep over registers 0..3: R7 and R8 via model
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int md = 0; md < 4; md++)
          for (int wd = 0; wd < 4; wd++)
            for (int f = 0; f < 4; f++)
              apply(a[REG_W-1:0], b[REG_W-1:0], md[REG_W-1:0], f[1], wd[REG_W-1:0], f[0],
                    model(a[REG_W-1:0], md[REG_W-1:0], f[1], wd[REG_W-1:0], f[0]),
                    model(b[REG_W-1:0], md[REG_W-1:0], f[1], wd[REG_W-1:0], f[0]),
                    "R7 sweep");
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule